// File: doc/BRIEF.md
# Outbound Address Window Translator

This block converts CPU-side physical addresses into bus-side addresses using a small set of programmable outbound windows (four by default). Each window covers a range of whole megabytes, from a start megabyte to a last megabyte, both inclusive. It also holds a 64-bit bus-side address that the first byte of the window maps to. When a CPU address falls inside a window, the block reports a hit, the index of that window, and the translated bus address. When no window matches, it reports a miss.

Software sets up the windows through a 32-bit register write port. Each megabyte number is 20 bits wide. Its low 12 bits are written into a shared range word, one per window. Its upper 8 bits are written into a separate extension register, one for the start and one for the last megabyte. The bus-side address is written as two 32-bit halves.

A lookup is presented with `cpu_valid` and `cpu_addr`. Its result appears on the registered outputs one clock later. Forwarding, ordering and error responses are left to the logic around the block.

Top module: `owt_translator`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid` and `out_hit` are 0 after that edge. After reset every window is disabled: the start megabyte reads as all ones and the last megabyte as zero. Any lookup therefore misses.
- R2: Address `a` hits window `w` when start_mb(w) <= a[39:20] <= last_mb(w). The last megabyte is inclusive. The megabyte just past it misses, and so does the megabyte just before the start. A window whose start equals its last megabyte covers exactly one megabyte.
- R3: On a hit, `out_addr` equals bus_base(w) + a − start_mb(w)·2^20, computed modulo 2^64.
- R4: A window whose last megabyte is below its start megabyte never hits.
- R5: When several windows match, `out_win` is the lowest-numbered of them, and `out_addr` uses that window's values.
- R6: `out_valid` at each rising edge takes the value `cpu_valid` had just before it, so results arrive exactly one cycle after the lookup. Back-to-back lookups give back-to-back results. When `out_valid` is 0, `out_hit` is 0.
- R7: On a miss (`out_valid`=1, `out_hit`=0), `out_win` and `out_addr` are 0.
- R8: Range word of window w, at byte offset 0x20+4w:
  - bits 15:4 hold the low 12 bits of the start megabyte;
  - bits 31:20 hold the low 12 bits of the last megabyte;
  - all other bits are ignored.
- R9: Extension registers for window w:
  - offset 0x30+8w, bits 7:0, set bits 19:12 of the start megabyte;
  - offset 0x34+8w, bits 7:0, set bits 19:12 of the last megabyte.

  These registers give windows above the first 4 GB.
- R10: Bus-side base of window w:
  - offset 0x00+8w writes bits 31:0;
  - offset 0x04+8w writes bits 63:32.
- R11: A write to any offset not listed in R8 to R10 changes no window. This includes misaligned offsets such as 0x22 and offsets beyond the map such as 0x50.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register byte offset |
| wr_data | input | 32 | Register write data |
| cpu_valid | input | 1 | Lookup request |
| cpu_addr | input | 40 | CPU physical address to translate |
| out_valid | output | 1 | Result valid, one cycle after `cpu_valid` |
| out_hit | output | 1 | Address fell in an enabled window |
| out_win | output | 2 | Index of the matching window |
| out_addr | output | 64 | Translated bus-side address |

## Verification
- **Lookup latency.** Every lookup result is due one rising edge after the cycle in which `cpu_valid` is presented. The bench drives inputs on falling edges and reads the outputs at the next falling edge, which is half a cycle after the capturing edge.
- **Write latency.** A register write takes effect at the edge that samples it, so the bench issues lookups only on cycles after the write strobe has dropped.
- **Back-to-back lookups.** The bench checks each result at the falling edge that follows its own capturing edge, and checks that `out_valid` drops one cycle after the stream ends.

// File: rtl/owt_pkg.sv
// Shared constants and types for the outbound window translator.
// Assumes: 40-bit CPU addresses, 1 MB window granularity, 64-bit bus addresses.
package owt_pkg;
    localparam int CPU_AW      = 40;
    localparam int BUS_AW      = 64;
    localparam int REG_DW      = 32;
    localparam int MB_SHIFT    = 20;
    localparam int MB_LO_W     = 12;
    localparam int MB_HI_W     = 8;
    localparam int MB_W        = MB_LO_W + MB_HI_W;
    // Field positions inside the per-window range word
    localparam int START_LSB   = 4;
    localparam int LAST_LSB    = 20;
    // Register map offsets and strides
    localparam int OFF_BUS_LO   = 'h00;
    localparam int OFF_BUS_HI   = 'h04;
    localparam int OFF_RANGE    = 'h20;
    localparam int OFF_START_HI = 'h30;
    localparam int OFF_LAST_HI  = 'h34;
    localparam int PAIR_STRIDE  = 8;
    localparam int RANGE_STRIDE = 4;

    typedef struct packed {
        logic [MB_W-1:0]   start_mb;
        logic [MB_W-1:0]   last_mb;
        logic [BUS_AW-1:0] bus_base;
    } win_cfg_t;
endpackage

// File: rtl/owt_regfile.sv
// Window configuration storage. Decodes byte-offset writes into per-window
// start/last megabyte fields and bus base words.
// Assumes: the map holds at most four windows before the range words run
// into the extension registers; unknown offsets are dropped.
module owt_regfile
    import owt_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int ADDR_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    output win_cfg_t          cfg [NUM_WIN]
);
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam int A_BUS_LO   = OFF_BUS_LO   + PAIR_STRIDE * i;
        localparam int A_BUS_HI   = OFF_BUS_HI   + PAIR_STRIDE * i;
        localparam int A_RANGE    = OFF_RANGE    + RANGE_STRIDE * i;
        localparam int A_START_HI = OFF_START_HI + PAIR_STRIDE * i;
        localparam int A_LAST_HI  = OFF_LAST_HI  + PAIR_STRIDE * i;

        win_cfg_t q;

        // Update one window's fields from matching register writes
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q.start_mb <= '1;
                q.last_mb  <= '0;
                q.bus_base <= '0;
            end else if (wr_en) begin
                if (wr_addr == ADDR_W'(A_BUS_LO))
                    q.bus_base[31:0] <= wr_data;
                if (wr_addr == ADDR_W'(A_BUS_HI))
                    q.bus_base[63:32] <= wr_data;
                if (wr_addr == ADDR_W'(A_RANGE)) begin
                    q.start_mb[MB_LO_W-1:0] <= wr_data[START_LSB +: MB_LO_W];
                    q.last_mb[MB_LO_W-1:0]  <= wr_data[LAST_LSB  +: MB_LO_W];
                end
                if (wr_addr == ADDR_W'(A_START_HI))
                    q.start_mb[MB_W-1:MB_LO_W] <= wr_data[MB_HI_W-1:0];
                if (wr_addr == ADDR_W'(A_LAST_HI))
                    q.last_mb[MB_W-1:MB_LO_W] <= wr_data[MB_HI_W-1:0];
            end
        end

        assign cfg[i] = q;
    end
endmodule

// File: rtl/owt_match.sv
// Parallel window compare and priority select. Every window compares the
// address megabyte against its inclusive range and forms its own translation;
// the lowest-numbered matching window is chosen.
// Assumes: purely combinational; the caller registers the result.
module owt_match
    import owt_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int WIN_W   = 2
) (
    input  win_cfg_t          cfg [NUM_WIN],
    input  logic [CPU_AW-1:0] addr,
    output logic              hit,
    output logic [WIN_W-1:0]  win_idx,
    output logic [BUS_AW-1:0] bus_addr
);
    logic [MB_W-1:0]   addr_mb;
    logic [NUM_WIN-1:0] in_rng;
    logic [BUS_AW-1:0] xl [NUM_WIN];

    assign addr_mb = addr[CPU_AW-1:MB_SHIFT];

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        logic              enabled;
        logic [CPU_AW-1:0] offset;
        assign enabled   = cfg[i].last_mb >= cfg[i].start_mb;
        assign in_rng[i] = enabled && (addr_mb >= cfg[i].start_mb)
                                   && (addr_mb <= cfg[i].last_mb);
        assign offset    = addr - {cfg[i].start_mb, {MB_SHIFT{1'b0}}};
        assign xl[i]     = cfg[i].bus_base + BUS_AW'(offset);
    end

    // Pick the lowest-numbered window that matches
    always_comb begin
        hit      = 1'b0;
        win_idx  = '0;
        bus_addr = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (in_rng[i] && !hit) begin
                hit      = 1'b1;
                win_idx  = WIN_W'(i);
                bus_addr = xl[i];
            end
        end
    end
endmodule

// File: rtl/owt_translator.sv
// Outbound address window translator top. Holds the window registers,
// matches each presented CPU address and registers the result once.
// Assumes: lookups see register state as of the previous clock edge.
module owt_translator
    import owt_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int ADDR_W  = 7,
    localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic              cpu_valid,
    input  logic [CPU_AW-1:0] cpu_addr,
    output logic              out_valid,
    output logic              out_hit,
    output logic [WIN_W-1:0]  out_win,
    output logic [BUS_AW-1:0] out_addr
);
    win_cfg_t          cfg [NUM_WIN];
    logic              m_hit;
    logic [WIN_W-1:0]  m_idx;
    logic [BUS_AW-1:0] m_addr;

    owt_regfile #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    owt_match #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_match (
        .cfg      (cfg),
        .addr     (cpu_addr),
        .hit      (m_hit),
        .win_idx  (m_idx),
        .bus_addr (m_addr)
    );

    // Register the lookup result; a miss or idle cycle drives zeros
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_win   <= '0;
            out_addr  <= '0;
        end else begin
            out_valid <= cpu_valid;
            out_hit   <= cpu_valid && m_hit;
            out_win   <= (cpu_valid && m_hit) ? m_idx  : '0;
            out_addr  <= (cpu_valid && m_hit) ? m_addr : '0;
        end
    end
endmodule

// File: rtl/owt_checker.sv
// Port-level properties of the translator, bound to the top module.
module owt_checker
    import owt_pkg::*;
#(
    parameter int WIN_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic              out_valid,
    input logic              out_hit,
    input logic [WIN_W-1:0]  out_win,
    input logic [BUS_AW-1:0] out_addr
);
    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |=> out_valid);

    assert_idle_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_valid |=> !out_valid);

    assert_no_hit_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_hit);

    assert_miss_is_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> (out_win == '0 && out_addr == '0));

    assert_addr_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> !$isunknown(out_addr));
endmodule

bind owt_translator owt_checker #(.WIN_W(WIN_W)) u_owt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_valid (cpu_valid),
    .out_valid (out_valid),
    .out_hit   (out_hit),
    .out_win   (out_win),
    .out_addr  (out_addr)
);

// File: tb/test_owt_translator.sv
module test_owt_translator;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [6:0]  wr_addr;
    logic [31:0] wr_data;
    logic        cpu_valid;
    logic [39:0] cpu_addr;
    logic        out_valid;
    logic        out_hit;
    logic [1:0]  out_win;
    logic [63:0] out_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    owt_translator i_owt_translator (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
        .out_valid(out_valid), .out_hit(out_hit), .out_win(out_win),
        .out_addr(out_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] xlate(logic [63:0] bus, logic [39:0] a, logic [19:0] smb);
        return bus + {24'd0, a} - ({44'd0, smb} << 20);
    endfunction

    function automatic logic [39:0] mk_addr(logic [19:0] mb, logic [19:0] ofs);
        return {mb, ofs};
    endfunction

    task automatic check_out(string req, logic ev, logic eh, logic [1:0] ew, logic [63:0] ea);
        n_checks++;
        if (out_valid !== ev || out_hit !== eh || out_win !== ew || out_addr !== ea) begin
            n_fail++;
            $display("FAIL %s: got v=%0b h=%0b w=%0d a=%h, expected v=%0b h=%0b w=%0d a=%h",
                     req, out_valid, out_hit, out_win, out_addr, ev, eh, ew, ea);
        end
    endtask

    task automatic reg_write(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic program_win(int w, logic [19:0] smb, logic [19:0] lmb, logic [63:0] bus);
        reg_write(7'(8*w),        bus[31:0]);   // R10 low word
        reg_write(7'(8*w + 4),    bus[63:32]);  // R10 high word
        reg_write(7'('h20 + 4*w), {lmb[11:0], 4'd0, smb[11:0], 4'd0}); // R8
        reg_write(7'('h30 + 8*w), {24'd0, smb[19:12]});                 // R9
        reg_write(7'('h34 + 8*w), {24'd0, lmb[19:12]});                 // R9
    endtask

    // One lookup; result sampled at the falling edge after the capturing edge
    task automatic lookup(string req, logic [39:0] a, logic eh, logic [1:0] ew, logic [63:0] ea);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = a;
        @(negedge clk);
        cpu_valid = 1'b0;
        check_out(req, 1'b1, eh, ew, ea);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; cpu_valid = 1'b1; cpu_addr = 0;
        repeat (3) @(negedge clk);
        check_out("R1 in reset", 1'b0, 1'b0, 2'd0, 64'd0);
        rst_n = 1'b1; cpu_valid = 1'b0;
        lookup("R1 miss after reset at 0", 40'd0, 1'b0, 2'd0, 64'd0);
        lookup("R1 miss after reset high", 40'hFF_FFF0_0000, 1'b0, 2'd0, 64'd0);
    endtask

    task automatic t_basic;
        logic [63:0] bb = 64'h0000_0001_0000_0000;
        program_win(0, 20'h00100, 20'h001FF, bb);
        lookup("R2 R3 R8 inside", mk_addr(20'h00100, 20'h00123), 1'b1, 2'd0,
               xlate(bb, mk_addr(20'h00100, 20'h00123), 20'h00100));
        lookup("R2 last MB inclusive", mk_addr(20'h001FF, 20'hFFFFF), 1'b1, 2'd0,
               xlate(bb, mk_addr(20'h001FF, 20'hFFFFF), 20'h00100));
        lookup("R2 R7 MB past last", mk_addr(20'h00200, 20'h0), 1'b0, 2'd0, 64'd0);
        lookup("R2 R7 MB before start", mk_addr(20'h000FF, 20'hFFFFF), 1'b0, 2'd0, 64'd0);
    endtask

    task automatic t_high;
        logic [63:0] bb = 64'hDEAD_0000_8000_0000;
        logic [39:0] a  = mk_addr(20'h12350, 20'hABCDE);
        program_win(1, 20'h12345, 20'h12400, bb);
        lookup("R9 R10 above 4GB", a, 1'b1, 2'd1, xlate(bb, a, 20'h12345));
        lookup("R9 last extended MB", mk_addr(20'h12400, 20'h00001), 1'b1, 2'd1,
               xlate(bb, mk_addr(20'h12400, 20'h00001), 20'h12345));
        lookup("R9 low bits alone miss", mk_addr(20'h00350, 20'h0), 1'b0, 2'd0, 64'd0);
    endtask

    task automatic t_priority;
        logic [63:0] b2 = 64'h0000_0040_0000_0000;
        logic [63:0] b3 = 64'h0000_0000_C000_0000;
        program_win(2, 20'h00150, 20'h00160, b2);
        lookup("R5 overlap picks lowest", mk_addr(20'h00155, 20'h00010), 1'b1, 2'd0,
               xlate(64'h0000_0001_0000_0000, mk_addr(20'h00155, 20'h00010), 20'h00100));
        program_win(3, 20'h03000, 20'h03010, b3);
        lookup("R3 window 3 translation", mk_addr(20'h03005, 20'h00042), 1'b1, 2'd3,
               xlate(b3, mk_addr(20'h03005, 20'h00042), 20'h03000));
    endtask

    task automatic t_disable;
        program_win(3, 20'h03000, 20'h02FFF, 64'h0000_0000_C000_0000);
        lookup("R4 last below start", mk_addr(20'h03005, 20'h00042), 1'b0, 2'd0, 64'd0);
        lookup("R4 below start", mk_addr(20'h02FFF, 20'h00000), 1'b0, 2'd0, 64'd0);
        program_win(2, 20'h00700, 20'h00700, 64'h0000_0000_0010_0000);
        lookup("R2 single MB window", mk_addr(20'h00700, 20'hFFFFF), 1'b1, 2'd2,
               xlate(64'h0000_0000_0010_0000, mk_addr(20'h00700, 20'hFFFFF), 20'h00700));
        lookup("R2 single MB next", mk_addr(20'h00701, 20'h0), 1'b0, 2'd0, 64'd0);
    endtask

    task automatic t_unmapped;
        reg_write(7'h50, 32'hFFFF_FFFF);
        reg_write(7'h22, 32'h0000_0000);
        reg_write(7'h01, 32'h0000_0000);
        lookup("R11 window 0 unchanged", mk_addr(20'h00100, 20'h00123), 1'b1, 2'd0,
               xlate(64'h0000_0001_0000_0000, mk_addr(20'h00100, 20'h00123), 20'h00100));
        lookup("R11 window 1 unchanged", mk_addr(20'h12350, 20'hABCDE), 1'b1, 2'd1,
               xlate(64'hDEAD_0000_8000_0000, mk_addr(20'h12350, 20'hABCDE), 20'h12345));
    endtask

    task automatic t_stream;
        logic [39:0] a0 = mk_addr(20'h00180, 20'h00001);
        logic [39:0] a1 = mk_addr(20'h12360, 20'h00002);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = a0;
        @(negedge clk);
        cpu_addr = a1;
        check_out("R6 stream first", 1'b1, 1'b1, 2'd0, xlate(64'h0000_0001_0000_0000, a0, 20'h00100));
        @(negedge clk);
        cpu_valid = 1'b0;
        check_out("R6 stream second", 1'b1, 1'b1, 2'd1, xlate(64'hDEAD_0000_8000_0000, a1, 20'h12345));
        @(negedge clk);
        check_out("R6 idle after stream", 1'b0, 1'b0, 2'd0, 64'd0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_high();
        t_priority();
        t_disable();
        t_unmapped();
        t_stream();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion within 20000 cycles");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule